// File: doc/BRIEF.md
# Lane-Keyed Iterative Feistel Cipher

This block encrypts one 32-bit block under a 64-bit key, running one Feistel round per clock for 32 rounds. A 2-bit lane input reorders the round keys inside every group of four, so one key gives four different permutations. A caller pulses `start_i` with the data, key and lane. Thirty-two cycles later `done_o` pulses for one cycle and `result_o` carries the ciphertext.

The round keys are never stored as a full table. The block keeps a window of four 16-bit words, which is the current group of four round keys. When the rounds of one group finish, the block replaces the window with the next four expanded words, computed in a single cycle.

Top module: `lane_feistel_cipher`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start, `done_o` is 0 and `result_o` is 0.
- R2: The key splits into words k0..k3: k0 = key[63:48], k1 = key[47:32], k2 = key[31:16], k3 = key[15:0].
- R3: The round keys are k4..k31. For i = 0..27: t = ror3(k[i+3]) ^ k[i+1], and k[i+4] = 0xFFFC ^ z_i ^ k[i] ^ t ^ ror1(t). The bit z_i is bit 63-i of 0xFA2561CDF44AC398 and is XORed into bit 0 only.
- R4: Round j (0..31) uses key k[4*(j/4) + ((j%4 + lane) % 4)].
- R5: Before round 0, left = data[15:0] and right = data[31:16].
- R6: Each round computes f = (rol1(left) & rol8(left)) ^ rol2(left), with all rotations on 16 bits. The new left is right ^ f ^ roundkey, and the new right is the old left.
- R7: `result_o` = {right, left} after exactly 32 rounds. `done_o` rises in the 32nd cycle after the clock edge that accepts `start_i`.
- R8: `done_o` stays high for one cycle only. `result_o` then keeps its value until the next accepted start.
- R9: `start_i` is ignored while a run is in progress. The run in progress completes with its own result and its own latency.
- R10: The key and lane are sampled when a start is accepted. Changes to them during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin encryption when idle |
| data_i | input | 32 | Plaintext block |
| key_i | input | 64 | Cipher key |
| lane_i | input | 2 | Round-key rotation within each group of four |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Ciphertext, held until the next start |

## Verification
A wrong word in the key window first corrupts one round. Every later round then mixes that error into both halves, so the fault shows up in `result_o` at the next `done_o`, 32 cycles after the start. A fault in the round counter or the busy flag shows up as a `done_o` pulse one or more cycles off from cycle 32, or as a missing pulse. A fault in the lane selection shows up only for nonzero lanes, so the vectors cover all four lanes under one key. A fault in the expansion step or the z-bit index shows up only once the window advances, so every vector runs the full 32 rounds.

// File: rtl/feistel_pkg.sv
package feistel_pkg;
  localparam int HALF_W    = 16;
  localparam int BLK_W     = 2 * HALF_W;
  localparam int KEY_WORDS = 4;
  localparam int KEY_W     = KEY_WORDS * HALF_W;
  localparam int ROUNDS    = 32;
  localparam int RND_W     = $clog2(ROUNDS);
  localparam int SEL_W     = $clog2(KEY_WORDS);
  localparam int GRP_W     = RND_W - SEL_W;
  localparam int ZI_W      = 6;

  localparam logic [HALF_W-1:0] EXP_C = 16'hFFFC;
  localparam logic [63:0]       Z_SEQ = 64'hFA2561CDF44AC398;

  typedef logic [HALF_W-1:0] word_t;

  function automatic word_t rotl(word_t v, int n);
    return (v << n) | (v >> (HALF_W - n));
  endfunction

  function automatic word_t rotr(word_t v, int n);
    return (v >> n) | (v << (HALF_W - n));
  endfunction

  // one key expansion step: a = k[i], b = k[i+1], d = k[i+3]
  function automatic word_t expand_step(word_t a, word_t b, word_t d, logic z);
    word_t t;
    t = rotr(d, 3) ^ b;
    return EXP_C ^ {{(HALF_W-1){1'b0}}, z} ^ a ^ t ^ rotr(t, 1);
  endfunction
endpackage

// File: rtl/feistel_key_window.sv
module feistel_key_window
  import feistel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             advance_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [SEL_W-1:0] sel_i,
  output word_t            rkey_o
);
  word_t win_q [KEY_WORDS];
  word_t ext   [2*KEY_WORDS];

  // next group: four chained expansion steps
  always_comb begin
    for (int t = 0; t < KEY_WORDS; t++) ext[t] = win_q[t];
    for (int t = 0; t < KEY_WORDS; t++) begin
      logic [ZI_W-1:0] zi;
      zi = ZI_W'(63) - ZI_W'({grp_i, SEL_W'(t)});
      ext[t+KEY_WORDS] = expand_step(ext[t], ext[t+1], ext[t+3], Z_SEQ[zi]);
    end
  end

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        win_q[w] <= '0;
      else if (load_i)    win_q[w] <= key_i[KEY_W-1-w*HALF_W -: HALF_W];
      else if (advance_i) win_q[w] <= ext[w+KEY_WORDS];
    end
  end

  assign rkey_o = win_q[sel_i];
endmodule

// File: rtl/feistel_round.sv
module feistel_round
  import feistel_pkg::*;
(
  input  word_t left_i,
  input  word_t right_i,
  input  word_t rkey_i,
  output word_t left_o,
  output word_t right_o
);
  word_t f;
  assign f       = (rotl(left_i, 1) & rotl(left_i, 8)) ^ rotl(left_i, 2);
  assign left_o  = right_i ^ f ^ rkey_i;
  assign right_o = left_i;
endmodule

// File: rtl/feistel_ctrl.sv
module feistel_ctrl
  import feistel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [RND_W-1:0] rnd_q;
  logic             busy_q, done_q, last;

  assign last   = (rnd_q == RND_W'(ROUNDS-1));
  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        rnd_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rnd_q <= rnd_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rnd_o  = rnd_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/lane_feistel_cipher.sv
module lane_feistel_cipher
  import feistel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] data_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [SEL_W-1:0] lane_i,
  output logic             done_o,
  output logic [BLK_W-1:0] result_o
);
  logic             load, step, busy_q, advance;
  logic [RND_W-1:0] rnd;
  logic [SEL_W-1:0] lane_q, sel;
  word_t            left_q, right_q, left_d, right_d, rkey;

  feistel_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o (load),
    .step_o (step),
    .rnd_o  (rnd),
    .busy_o (busy_q),
    .done_o
  );

  assign sel     = rnd[SEL_W-1:0] + lane_q;
  assign advance = step && (&rnd[SEL_W-1:0]) && (rnd != RND_W'(ROUNDS-1));

  feistel_key_window u_keys (
    .clk_i, .rst_ni,
    .load_i    (load),
    .key_i,
    .advance_i (advance),
    .grp_i     (rnd[RND_W-1:SEL_W]),
    .sel_i     (sel),
    .rkey_o    (rkey)
  );

  feistel_round u_round (
    .left_i  (left_q),
    .right_i (right_q),
    .rkey_i  (rkey),
    .left_o  (left_d),
    .right_o (right_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
      lane_q  <= '0;
    end else if (load) begin
      left_q  <= data_i[HALF_W-1:0];
      right_q <= data_i[BLK_W-1:HALF_W];
      lane_q  <= lane_i;
    end else if (step) begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  assign result_o = {right_q, left_q};
endmodule

// File: rtl/feistel_checker.sv
module feistel_checker
  import feistel_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_o,
  input logic [BLK_W-1:0] result_o
);
  logic [RND_W:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i && !busy_i) cnt_q <= '0;
    else if (busy_i)             cnt_q <= cnt_q + 1'b1;
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == (RND_W+1)'(ROUNDS)));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(result_o));

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i && cnt_q < (RND_W+1)'(ROUNDS-1)) |=> (busy_i && !done_o));

  a_r7_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);
endmodule

bind lane_feistel_cipher feistel_checker u_chk (
  .clk_i, .rst_ni, .start_i,
  .busy_i (busy_q),
  .done_o, .result_o
);

// File: tb/lane_feistel_cipher_tb.sv
module lane_feistel_cipher_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [63:0] key_i = '0;
  logic [1:0]  lane_i = '0;
  logic        done_o;
  logic [31:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  lane_feistel_cipher u_dut (.*);

  function automatic logic [15:0] r16l(logic [15:0] v, int n);
    return (v << n) | (v >> (16 - n));
  endfunction

  // reference model written from R2..R7
  function automatic logic [31:0] model(logic [31:0] d, logic [63:0] k, logic [1:0] ln);
    logic [15:0] ks [32];
    logic [15:0] l, r, t, f, nl;
    logic [63:0] zc;
    zc = 64'hFA2561CDF44AC398;
    for (int w = 0; w < 4; w++) ks[w] = k[63-16*w -: 16];
    for (int i = 0; i < 28; i++) begin
      t = r16l(ks[i+3], 13) ^ ks[i+1];
      ks[i+4] = 16'hFFFC ^ {15'd0, zc[63-i]} ^ ks[i] ^ t ^ r16l(t, 15);
    end
    l = d[15:0];
    r = d[31:16];
    for (int j = 0; j < 32; j++) begin
      f  = (r16l(l, 1) & r16l(l, 8)) ^ r16l(l, 2);
      nl = r ^ f ^ ks[4*(j/4) + ((j%4 + int'(ln)) % 4)];
      r  = l;
      l  = nl;
    end
    return {r, l};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start at negedge, then returns at negedge 32 (done expected)
  task automatic run(logic [31:0] d, logic [63:0] k, logic [1:0] ln, string req);
    logic [31:0] exp;
    exp = model(d, k, ln);
    @(negedge clk_i);
    data_i = d; key_i = k; lane_i = ln; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (31) @(negedge clk_i);
    check(done_o === 1'b0, {req, " R7 early done"}, {31'd0, done_o}, 32'd0);
    @(negedge clk_i);
    check(done_o === 1'b1, {req, " R7 done at 32"}, {31'd0, done_o}, 32'd1);
    check(result_o === exp, req, result_o, exp);
  endtask

  localparam int NV = 8;
  // {data, key, lane}
  localparam logic [97:0] VEC [NV] = '{
    {32'h0000_0000, 64'h0000_0000_0000_0000, 2'd0},
    {32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0},
    {32'h1234_5678, 64'h0123_4567_89AB_CDEF, 2'd0},
    {32'h1234_5678, 64'h0123_4567_89AB_CDEF, 2'd1},
    {32'h1234_5678, 64'h0123_4567_89AB_CDEF, 2'd2},
    {32'h1234_5678, 64'h0123_4567_89AB_CDEF, 2'd3},
    {32'h8000_0001, 64'h8000_0000_0000_0001, 2'd2},
    {32'hDEAD_BEEF, 64'hFEDC_BA98_7654_3210, 2'd3}
  };

  initial begin
    #800000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp, held;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(done_o === 1'b0 && result_o === 32'd0, "R1 in reset", result_o, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(done_o === 1'b0 && result_o === 32'd0, "R1 after release", result_o, 32'd0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int v = 0; v < NV; v++)
      run(VEC[v][97:66], VEC[v][65:2], VEC[v][1:0], "R2/R3/R4/R5/R6 vector");

    // R4: lanes give distinct permutations
    check(model(32'h1234_5678, 64'h0123_4567_89AB_CDEF, 2'd0) !==
          model(32'h1234_5678, 64'h0123_4567_89AB_CDEF, 2'd1), "R4 lanes differ",
          32'd0, 32'd1);

    // R8: one-cycle pulse, result held
    held = result_o;
    @(negedge clk_i);
    check(done_o === 1'b0, "R8 done single cycle", {31'd0, done_o}, 32'd0);
    data_i = 32'hAAAA_5555; key_i = 64'h1111_2222_3333_4444;
    repeat (10) @(negedge clk_i);
    check(result_o === held, "R8 result held", result_o, held);

    // R9 start ignored while busy, R10 inputs sampled at start
    exp = model(32'hCAFE_F00D, 64'h0F0F_F0F0_1234_ABCD, 2'd1);
    @(negedge clk_i);
    data_i = 32'hCAFE_F00D; key_i = 64'h0F0F_F0F0_1234_ABCD; lane_i = 2'd1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    data_i = 32'h0; key_i = 64'hFFFF_0000_FFFF_0000; lane_i = 2'd3;
    repeat (9) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (21) @(negedge clk_i);
    check(done_o === 1'b0, "R9 no early done", {31'd0, done_o}, 32'd0);
    @(negedge clk_i);
    check(done_o === 1'b1, "R9 done on original schedule", {31'd0, done_o}, 32'd1);
    check(result_o === exp, "R9 R10 result of first start", result_o, exp);
    @(negedge clk_i);
    check(done_o === 1'b0, "R9 no second done", {31'd0, done_o}, 32'd0);

    // R7 back-to-back start right after done
    run(32'h0F1E_2D3C, 64'hA5A5_5A5A_C3C3_3C3C, 2'd2, "R7 back-to-back");

    // R1 reset mid-run
    @(negedge clk_i);
    data_i = 32'h1357_9BDF; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(result_o === 32'd0 && done_o === 1'b0, "R1 mid-run reset", result_o, 32'd0);
    rst_ni = 1'b1;
    begin
      bit seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk_i);
        if (done_o) seen = 1;
      end
      check(!seen, "R1 aborted run never completes", {31'd0, seen}, 32'd0);
    end
    run(32'h2468_ACE0, 64'h0000_0000_0000_0001, 2'd0, "R1 run after reset");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule